// File: doc/BRIEF.md
# Text Terminal Cursor Controller

This block turns a stream of 8-bit characters into updates of a character-cell text screen held in an external synchronous memory. It tracks the cursor position and stores printable characters at the cursor. It also interprets a small set of control codes: single-cell cursor moves, carriage return, line feed, erase-left, tab expansion and an audible beep. When text runs off the bottom row, or a line feed arrives on the bottom row, the block scrolls the whole screen up by one row. It does this by reading every cell below the top row and writing it one row higher, then blanking the bottom row.

Characters enter through a valid/ready byte port. Each accepted byte takes one cycle, except tab and scroll, which hold the port not-ready while they write several cells. The screen memory is reached through one registered write port and one read-address port. The read port returns data one cycle after the address is given and is used only while scrolling. Screen contents are not cleared at reset. The default geometry is 80 columns by 30 rows, with tab stops every 8 columns. Memory address is row*80+column.

Top module: `term_ctrl`

## Requirements
- R1: After reset the cursor is at row 0, column 0, `in_ready` is high, and `scr_we` and `beep` are low.
- R2: A printable byte (0x20 to 0x7E) is written unchanged to address row*80+column of the cursor, and the cursor then moves one column right.
- R3: A printable byte written at column 79 moves the cursor to column 0 of the next row. On row 29 the cursor goes to (29,0) and the screen scrolls instead.
- R4: Byte 0x0D puts the cursor in column 0 of its row and writes nothing.
- R5: Byte 0x0A moves the cursor down one row, keeping its column, and writes nothing. On row 29 the screen scrolls and the cursor stays put.
- R6: Bytes 0x02, 0x06, 0x10 and 0x0E move the cursor one cell left, right, up and down. A move that would leave the screen leaves the cursor where it is, without wrapping.
- R7: Byte 0x08 at a column above 0 moves the cursor one column left and writes a space (0x20) into the cell it moved to. At column 0 it changes nothing and writes nothing.
- R8: Byte 0x09 writes a space at the cursor and advances, one cell per cycle with `in_ready` low. It stops once the column is a multiple of 8. At column 79 it writes one space and the cursor stays at 79.
- R9: Byte 0x07 raises `beep` for one cycle, the cycle after acceptance, and neither writes nor moves the cursor.
- R10: While scrolling `in_ready` is low. Rows 1 to 29 are copied to rows 0 to 28, using the read port with one cycle of latency. Row 29 is then filled with spaces.
- R11: Every other byte (0x00 to 0x1F not listed above, and 0x7F to 0xFF) is accepted and has no effect on the screen or the cursor.
- R12: Writes and cursor updates are registered: they appear in the cycle after the byte is accepted, with at most one write per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can accept a byte this cycle |
| scr_we | output | 1 | Screen memory write enable |
| scr_waddr | output | 12 | Screen memory write address |
| scr_wdata | output | 8 | Screen memory write data |
| scr_raddr | output | 12 | Screen memory read address |
| scr_rdata | input | 8 | Screen memory read data, one cycle after address |
| beep | output | 1 | One-cycle beep pulse |
| cur_row | output | 5 | Cursor row |
| cur_col | output | 7 | Cursor column |

## Verification
The assertions assume two things about the surroundings. The screen memory returns, one cycle later, the byte held at the address driven on `scr_raddr`. No agent other than this block writes that memory. The bench memory model holds to both: a clocked read register and a write port fed only by `scr_we`. The bench drives `in_valid` and `in_data` only on falling edges and holds each byte until the rising edge that accepts it. Scrolls are started both by a line feed and by a character wrapping at the bottom-right cell, and each is checked against a snapshot of the screen taken just before.

// File: rtl/term_pkg.sv
package term_pkg;

    localparam logic [7:0] CH_SPACE = 8'h20;
    localparam logic [7:0] CH_BEEP  = 8'h07;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;
    localparam logic [7:0] CH_LEFT  = 8'h02;
    localparam logic [7:0] CH_RIGHT = 8'h06;
    localparam logic [7:0] CH_UP    = 8'h10;
    localparam logic [7:0] CH_DOWN  = 8'h0E;
    localparam logic [7:0] CH_ERASE = 8'h08;
    localparam logic [7:0] CH_TAB   = 8'h09;

    typedef enum logic [3:0] {
        ACT_NONE, ACT_PRINT, ACT_BEEP, ACT_CR, ACT_LF, ACT_LEFT,
        ACT_RIGHT, ACT_UP, ACT_DOWN, ACT_ERASE, ACT_TAB
    } act_e;

    typedef enum logic [1:0] { ST_IDLE, ST_TAB, ST_SCROLL } ctl_e;

    typedef enum logic [1:0] { SC_OFF, SC_COPY, SC_FILL } scr_e;

    typedef struct packed {
        logic wr;      // a cell is written
        logic blank;   // written byte is a space, not the input byte
        logic scroll;  // a scroll must follow
        logic more;    // tab needs further cells
    } mflags_t;

    function automatic logic is_printable(input logic [7:0] c);
        return (c >= 8'h20) && (c <= 8'h7E);
    endfunction

endpackage

// File: rtl/term_decode.sv
module term_decode
    import term_pkg::*;
(
    input  logic [7:0] code,
    output act_e       act
);
    always_comb begin
        if (is_printable(code)) begin
            act = ACT_PRINT;
        end else begin
            unique case (code)
                CH_BEEP:  act = ACT_BEEP;
                CH_CR:    act = ACT_CR;
                CH_LF:    act = ACT_LF;
                CH_LEFT:  act = ACT_LEFT;
                CH_RIGHT: act = ACT_RIGHT;
                CH_UP:    act = ACT_UP;
                CH_DOWN:  act = ACT_DOWN;
                CH_ERASE: act = ACT_ERASE;
                CH_TAB:   act = ACT_TAB;
                default:  act = ACT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/term_motion.sv
module term_motion
    import term_pkg::*;
#(
    parameter int COLS     = 80,
    parameter int ROWS     = 30,
    parameter int TAB_STOP = 8,
    localparam int CW = $clog2(COLS),
    localparam int RW = $clog2(ROWS)
) (
    input  act_e          act,
    input  logic [RW-1:0] row,
    input  logic [CW-1:0] col,
    output logic [RW-1:0] nrow,
    output logic [CW-1:0] ncol,
    output logic [CW-1:0] wcol,
    output mflags_t       fl
);
    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

    logic at_right, at_left, at_top, at_bottom;

    always_comb begin
        at_right  = (col == LAST_COL);
        at_left   = (col == '0);
        at_top    = (row == '0);
        at_bottom = (row == LAST_ROW);
        nrow = row;
        ncol = col;
        wcol = col;
        fl   = '0;
        unique case (act)
            ACT_PRINT: begin
                fl.wr = 1'b1;
                if (at_right) begin
                    ncol = '0;
                    if (at_bottom) fl.scroll = 1'b1;
                    else           nrow = row + RW'(1);
                end else begin
                    ncol = col + CW'(1);
                end
            end
            ACT_TAB: begin
                fl.wr    = 1'b1;
                fl.blank = 1'b1;
                if (!at_right) begin
                    ncol    = col + CW'(1);
                    fl.more = ((int'(ncol) % TAB_STOP) != 0);
                end
            end
            ACT_LF: begin
                if (at_bottom) fl.scroll = 1'b1;
                else           nrow = row + RW'(1);
            end
            ACT_CR:    ncol = '0;
            ACT_LEFT:  if (!at_left)   ncol = col - CW'(1);
            ACT_RIGHT: if (!at_right)  ncol = col + CW'(1);
            ACT_UP:    if (!at_top)    nrow = row - RW'(1);
            ACT_DOWN:  if (!at_bottom) nrow = row + RW'(1);
            ACT_ERASE: begin
                if (!at_left) begin
                    ncol     = col - CW'(1);
                    wcol     = col - CW'(1);
                    fl.wr    = 1'b1;
                    fl.blank = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/term_scroll.sv
module term_scroll
    import term_pkg::*;
#(
    parameter int COLS = 80,
    parameter int ROWS = 30,
    localparam int AW  = $clog2(COLS * ROWS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [7:0]    rdata,
    output logic [AW-1:0] raddr,
    output logic          rd_active,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [7:0]    wdata,
    output logic          done
);
    localparam logic [AW-1:0] COLS_A    = AW'(COLS);
    localparam logic [AW-1:0] LAST_A    = AW'(COLS * ROWS - 1);
    localparam logic [AW-1:0] FILL_BASE = AW'(COLS * (ROWS - 1));

    scr_e          phase;
    logic [AW-1:0] src;
    logic [AW-1:0] fill;
    logic          pend;
    logic [AW-1:0] pend_addr;

    always_comb begin
        raddr     = src;
        rd_active = (phase == SC_COPY);
        we        = pend || (phase == SC_FILL);
        waddr     = pend ? pend_addr : fill;
        wdata     = pend ? rdata : CH_SPACE;
        done      = (phase == SC_FILL) && !pend && (fill == LAST_A);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= SC_OFF;
            src       <= '0;
            fill      <= '0;
            pend      <= 1'b0;
            pend_addr <= '0;
        end else begin
            pend      <= (phase == SC_COPY);
            pend_addr <= src - COLS_A;
            unique case (phase)
                SC_OFF: if (go) begin
                    phase <= SC_COPY;
                    src   <= COLS_A;
                end
                SC_COPY: begin
                    if (src == LAST_A) begin
                        phase <= SC_FILL;
                        fill  <= FILL_BASE;
                    end else begin
                        src <= src + AW'(1);
                    end
                end
                SC_FILL: if (!pend) begin
                    if (fill == LAST_A) phase <= SC_OFF;
                    else                fill  <= fill + AW'(1);
                end
                default: phase <= SC_OFF;
            endcase
        end
    end

    // Copy writes land only in rows 0..ROWS-2
    assert_copy_row_bound_R10: assert property (@(posedge clk) disable iff (rst)
        (phase == SC_COPY && pend) |-> (waddr < FILL_BASE));

    // Fill phase writes only spaces into the last row
    assert_fill_last_row_R10: assert property (@(posedge clk) disable iff (rst)
        (we && !pend) |-> (waddr >= FILL_BASE && wdata == CH_SPACE));

endmodule

// File: rtl/term_ctrl.sv
module term_ctrl
    import term_pkg::*;
#(
    parameter int COLS     = 80,
    parameter int ROWS     = 30,
    parameter int TAB_STOP = 8,
    localparam int CW = $clog2(COLS),
    localparam int RW = $clog2(ROWS),
    localparam int AW = $clog2(COLS * ROWS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    output logic          in_ready,
    output logic          scr_we,
    output logic [AW-1:0] scr_waddr,
    output logic [7:0]    scr_wdata,
    output logic [AW-1:0] scr_raddr,
    input  logic [7:0]    scr_rdata,
    output logic          beep,
    output logic [RW-1:0] cur_row,
    output logic [CW-1:0] cur_col
);
    localparam logic [AW-1:0] COLS_A   = AW'(COLS);
    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

    ctl_e          state;
    act_e          dec_act;
    act_e          mot_act;
    logic [RW-1:0] nrow;
    logic [CW-1:0] ncol;
    logic [CW-1:0] wcol;
    mflags_t       fl;
    logic          accept;
    logic          step;

    logic          sc_rd;
    logic          sc_we;
    logic [AW-1:0] sc_waddr;
    logic [7:0]    sc_wdata;
    logic          sc_done;

    term_decode u_decode (
        .code (in_data),
        .act  (dec_act)
    );

    assign mot_act = (state == ST_TAB) ? ACT_TAB : dec_act;

    term_motion #(.COLS(COLS), .ROWS(ROWS), .TAB_STOP(TAB_STOP)) u_motion (
        .act  (mot_act),
        .row  (cur_row),
        .col  (cur_col),
        .nrow (nrow),
        .ncol (ncol),
        .wcol (wcol),
        .fl   (fl)
    );

    term_scroll #(.COLS(COLS), .ROWS(ROWS)) u_scroll (
        .clk       (clk),
        .rst       (rst),
        .go        (state == ST_SCROLL),
        .rdata     (scr_rdata),
        .raddr     (scr_raddr),
        .rd_active (sc_rd),
        .we        (sc_we),
        .waddr     (sc_waddr),
        .wdata     (sc_wdata),
        .done      (sc_done)
    );

    assign in_ready = (state == ST_IDLE);
    assign accept   = in_valid && in_ready;
    assign step     = accept || (state == ST_TAB);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_row   <= '0;
            cur_col   <= '0;
            scr_we    <= 1'b0;
            scr_waddr <= '0;
            scr_wdata <= '0;
            beep      <= 1'b0;
        end else begin
            scr_we <= 1'b0;
            beep   <= 1'b0;
            if (step) begin
                cur_row <= nrow;
                cur_col <= ncol;
                if (fl.wr) begin
                    scr_we    <= 1'b1;
                    scr_waddr <= AW'(cur_row) * COLS_A + AW'(wcol);
                    scr_wdata <= fl.blank ? CH_SPACE : in_data;
                end
                if (state == ST_IDLE) beep <= (dec_act == ACT_BEEP);
                if (fl.scroll)    state <= ST_SCROLL;
                else if (fl.more) state <= ST_TAB;
                else              state <= ST_IDLE;
            end else if (state == ST_SCROLL) begin
                scr_we    <= sc_we;
                scr_waddr <= sc_waddr;
                scr_wdata <= sc_wdata;
                if (sc_done) state <= ST_IDLE;
            end
        end
    end

    assert_cursor_on_screen_R6: assert property (@(posedge clk) disable iff (rst)
        (cur_col <= LAST_COL) && (cur_row <= LAST_ROW));

    assert_left_clamp_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && in_data == CH_LEFT && cur_col == '0) |=> (cur_col == '0));

    assert_lf_next_row_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && in_data == CH_LF && cur_row != LAST_ROW)
        |=> (cur_row == $past(cur_row) + RW'(1)) && (cur_col == $past(cur_col)));

    assert_beep_no_write_R9: assert property (@(posedge clk) disable iff (rst)
        beep |-> !scr_we);

    assert_tab_stop_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_TAB && state == ST_IDLE)
        |-> ((int'(cur_col) % TAB_STOP) == 0 || cur_col == LAST_COL));

    assert_scroll_blocks_input_R10: assert property (@(posedge clk) disable iff (rst)
        sc_rd |-> !in_ready);

    assert_ignored_code_R11: assert property (@(posedge clk) disable iff (rst)
        (accept && dec_act == ACT_NONE)
        |=> !scr_we && $stable(cur_row) && $stable(cur_col));

endmodule

// File: tb/term_ctrl_bench.sv
module term_ctrl_bench;
    localparam int COLS = 80;
    localparam int ROWS = 30;
    localparam int N    = COLS * ROWS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        scr_we;
    logic [11:0] scr_waddr;
    logic [7:0]  scr_wdata;
    logic [11:0] scr_raddr;
    logic [7:0]  scr_rdata;
    logic        beep;
    logic [4:0]  cur_row;
    logic [6:0]  cur_col;

    logic [7:0] mem  [0:N-1];
    logic [7:0] snap [0:N-1];

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    term_ctrl u_term_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .scr_we(scr_we), .scr_waddr(scr_waddr),
        .scr_wdata(scr_wdata), .scr_raddr(scr_raddr), .scr_rdata(scr_rdata),
        .beep(beep), .cur_row(cur_row), .cur_col(cur_col)
    );

    // screen memory model: synchronous read, one write port
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) mem[i] <= 8'h41 + 8'(i % 26);
        end else if (scr_we) begin
            mem[scr_waddr] <= scr_wdata;
        end
        scr_rdata <= mem[scr_raddr];
    end

    function automatic logic [7:0] pat(input int i);
        return 8'h41 + 8'(i % 26);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic settle();
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_n(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            send(b);
            settle();
        end
    endtask

    task automatic take_snap();
        for (int i = 0; i < N; i++) snap[i] = mem[i];
    endtask

    // rows 0..27 take snapshot rows 1..28, row 28 takes snapshot row 29
    task automatic chk_scrolled(input string req);
        int bad = 0;
        for (int i = 0; i < N - COLS; i++) if (mem[i] != snap[i + COLS]) bad++;
        chk({req, " rows moved up"}, bad, 0);
        bad = 0;
        for (int i = N - COLS; i < N; i++) if (mem[i] != 8'h20) bad++;
        chk({req, " last row blank"}, bad, 0);
    endtask

    // code, expected row, expected col after the byte
    localparam int NV = 15;
    localparam logic [19:0] VEC [0:NV-1] = '{
        {8'h41, 5'd0, 7'd1},    // R2 printable
        {8'h06, 5'd0, 7'd2},    // R6 right
        {8'h0D, 5'd0, 7'd0},    // R4 carriage return
        {8'h02, 5'd0, 7'd0},    // R6 left clamp
        {8'h10, 5'd0, 7'd0},    // R6 up clamp
        {8'h0E, 5'd1, 7'd0},    // R6 down
        {8'h0A, 5'd2, 7'd0},    // R5 line feed
        {8'h09, 5'd2, 7'd8},    // R8 tab
        {8'h78, 5'd2, 7'd9},    // R2
        {8'h09, 5'd2, 7'd16},   // R8 tab
        {8'h78, 5'd2, 7'd17},   // R2
        {8'h08, 5'd2, 7'd16},   // R7 erase
        {8'h1B, 5'd2, 7'd16},   // R11 ignored
        {8'hFF, 5'd2, 7'd16},   // R11 ignored
        {8'h07, 5'd2, 7'd16}    // R9 beep
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual running expected finished");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 row", int'(cur_row), 0);
        chk("R1 col", int'(cur_col), 0);
        chk("R1 ready", int'(in_ready), 1);
        chk("R1 we", int'(scr_we), 0);
        chk("R1 beep", int'(beep), 0);

        for (int v = 0; v < NV; v++) begin
            send(VEC[v][19:12]);
            settle();
            chk($sformatf("table step %0d row", v), int'(cur_row), int'(VEC[v][11:7]));
            chk($sformatf("table step %0d col", v), int'(cur_col), int'(VEC[v][6:0]));
        end

        chk("R2 cell 0", int'(mem[0]), 8'h41);
        chk("R5 R6 row1 untouched", int'(mem[80]), int'(pat(80)));
        begin
            int bad = 0;
            for (int i = 160; i < 168; i++) if (mem[i] != 8'h20) bad++;
            for (int i = 169; i < 177; i++) if (mem[i] != 8'h20) bad++;
            chk("R8 R7 tab spaces and erased cell", bad, 0);
        end
        chk("R2 x at col 8", int'(mem[168]), 8'h78);
        chk("R8 stop cell untouched", int'(mem[177]), int'(pat(177)));

        // R9 beep timing
        send(8'h07);
        chk("R9 beep pulse", int'(beep), 1);
        chk("R9 no write", int'(scr_we), 0);
        @(negedge clk);
        chk("R9 beep one cycle", int'(beep), 0);

        // R11 ignored code
        send(8'h1B);
        chk("R11 no write", int'(scr_we), 0);
        settle();
        chk("R11 col kept", int'(cur_col), 16);

        // back to home and to the right edge
        send_n(8'h0D, 1);
        send_n(8'h10, 2);
        send_n(8'h06, 79);
        chk("R6 right to 79", int'(cur_col), 79);
        send_n(8'h06, 1);
        chk("R6 right clamp", int'(cur_col), 79);

        // R8 tab at last column
        send(8'h09);
        chk("R8 R12 tab write addr", int'(scr_waddr), 79);
        chk("R8 tab write data", int'(scr_wdata), 8'h20);
        settle();
        chk("R8 tab stays 79", int'(cur_col), 79);
        chk("R8 cell 79 space", int'(mem[79]), 8'h20);

        // R3 wrap mid screen
        send(8'h71);
        chk("R12 write we", int'(scr_we), 1);
        chk("R12 write addr", int'(scr_waddr), 79);
        settle();
        chk("R3 wrap row", int'(cur_row), 1);
        chk("R3 wrap col", int'(cur_col), 0);
        chk("R2 q stored", int'(mem[79]), 8'h71);

        // down clamp then walk to bottom-right
        send_n(8'h0E, 40);
        chk("R6 down clamp", int'(cur_row), 29);
        send_n(8'h06, 79);
        take_snap();
        snap[N-1] = 8'h5A;
        send(8'h5A);
        chk("R10 ready low", int'(in_ready), 0);
        chk("R3 last cell addr", int'(scr_waddr), N - 1);
        settle();
        chk("R3 scroll row", int'(cur_row), 29);
        chk("R3 scroll col", int'(cur_col), 0);
        chk_scrolled("R10 R3");

        // R5 line feed on last row
        send_n(8'h06, 5);
        take_snap();
        send(8'h0A);
        chk("R5 ready low", int'(in_ready), 0);
        settle();
        chk("R5 row kept", int'(cur_row), 29);
        chk("R5 col kept", int'(cur_col), 5);
        chk_scrolled("R5");

        // R7 erase at column 0
        send_n(8'h0D, 1);
        send(8'h08);
        chk("R7 no write at col 0", int'(scr_we), 0);
        settle();
        chk("R7 col stays 0", int'(cur_col), 0);

        report();
    end
endmodule